// File: doc/BRIEF.md
# Match-Controlled Timer Counter

This block is a 32-bit interval timer. A prescale counter divides the clock. Each time the prescale counter reaches a programmable limit, it wraps and advances a timer counter by one. Three match registers are compared against the timer counter. Each comparison owns three action bits, and each channel picks any mix of them:

- flag an interrupt;
- send the timer counter back to zero;
- halt counting and drop the run bit, so software has to restart the timer.

Software reaches every register through a single-cycle synchronous write port and a combinational read port. Interrupt flags are sticky and are cleared by writing ones to them. One interrupt line is raised while any flag is set.

Top module: `match_timer`

## Requirements
- R1: After synchronous reset every register reads zero and `irq` is low. The word addresses are: 0 control, 1 prescale limit, 2 action word, 3 flags, 4/5/6 match values 0/1/2, 12 timer counter (read-only), 13 prescale counter (read-only). Writable registers read back what was written.
- R2: While running (control bit 0 set, bit 1 clear), the prescale counter rises by one every clock. On the clock where it equals the prescale limit, it returns to 0 and the timer counter rises by one, so the timer advances once every limit+1 clocks.
- R3: In the action word, channel i uses bit 3i for interrupt, bit 3i+1 for reset and bit 3i+2 for stop. Bits 9 and above read as zero.
- R4: A match event on channel i happens on a clock where the timer is running, the prescale counter wraps, and the timer counter equals match value i.
- R5: A match event on a channel with its interrupt bit set makes flag bit i (address 3, bit i) read 1 from the next clock onward, and `irq` is high whenever any flag is set.
- R6: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. Once every flag is clear, `irq` falls.
- R7: A match event with the reset bit set moves the timer counter from the match value straight to 0; it never shows the match value plus one.
- R8: A match event with the stop bit set has these effects:
  - the timer counter holds its value;
  - the prescale counter is at 0;
  - control bit 0 reads 0.

  Counting resumes only after software writes control bit 0 again.
- R9: While control bit 1 is set, both counters stay at 0 whatever bit 0 holds.
- R10: When several channels match on one clock, every enabled action is applied. Stop wins over counting on, and reset together with stop leaves the timer halted at 0.
- R11: A match event on a channel whose three action bits are zero has no effect: the timer counts past the match value and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| addr | input | 4 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | High while any flag is set |

## Verification
- A register write lands on the rising edge where `wr_en` is sampled, and the read port reflects it from that edge onward. The bench therefore reads on the falling edge after the write.
- Once control bit 0 is written, the first prescale step is on the next edge. After k further edges the timer holds floor(k/(limit+1)) when no match action fires. Every vector computes its expected value from that edge count.
- Match consequences appear one edge after the event clock: the flag set, the counter reset or hold, and the run bit drop. The bench samples them on falling edges at computed offsets and never relies on an edge where the value is still changing.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    localparam int unsigned REG_W  = 32;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned ACT_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_LIMIT = 4'd1;
    localparam logic [ADDR_W-1:0] A_ACT   = 4'd2;
    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd3;
    localparam logic [ADDR_W-1:0] A_MBASE = 4'd4;
    localparam logic [ADDR_W-1:0] A_TC    = 4'd12;
    localparam logic [ADDR_W-1:0] A_PC    = 4'd13;

    // Per-channel action bits; field order follows the action word layout.
    typedef struct packed {
        logic stop;
        logic clr;
        logic intr;
    } chan_act_t;

    typedef struct packed {
        logic halt;
        logic run;
    } ctrl_t;

    function automatic chan_act_t act_of(input logic [ACT_W-1:0] bits);
        return chan_act_t'(bits);
    endfunction

endpackage

// File: rtl/mtc_prescaler.sv
module mtc_prescaler #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_zero,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic [W-1:0] pc,
    output logic         tick
);

    assign tick = run && (pc == limit);

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            pc <= '0;
        end else if (run) begin
            pc <= tick ? '0 : pc + W'(1);
        end
    end

    p_hold_zero_r9: assert property (@(posedge clk) disable iff (rst)
        hold_zero |=> (pc == '0));

    p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !hold_zero) |=> $stable(pc));

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !hold_zero) |=> (pc == '0));

endmodule

// File: rtl/mtc_match_unit.sv
module mtc_match_unit
    import mtc_pkg::*;
#(
    parameter int unsigned W = 32,
    parameter int unsigned N = 3
) (
    input  logic [N-1:0][W-1:0]     mval,
    input  logic [N*ACT_W-1:0]      act_word,
    input  logic [W-1:0]            tc,
    input  logic                    tick,
    output logic [N-1:0]            hit_intr,
    output logic                    any_clr,
    output logic                    any_stop
);

    logic [N-1:0] hit_clr;
    logic [N-1:0] hit_stop;

    for (genvar i = 0; i < N; i++) begin : g_chan
        chan_act_t act;
        logic      event_i;
        assign act         = act_of(act_word[ACT_W*i +: ACT_W]);
        assign event_i     = tick && (tc == mval[i]);
        assign hit_intr[i] = event_i && act.intr;
        assign hit_clr[i]  = event_i && act.clr;
        assign hit_stop[i] = event_i && act.stop;
    end

    assign any_clr  = |hit_clr;
    assign any_stop = |hit_stop;

endmodule

// File: rtl/mtc_timer_count.sv
module mtc_timer_count #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_zero,
    input  logic         tick,
    input  logic         match_clr,
    input  logic         match_stop,
    output logic [W-1:0] tc
);

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            tc <= '0;
        end else if (tick) begin
            if (match_clr) begin
                tc <= '0;
            end else if (!match_stop) begin
                tc <= tc + W'(1);
            end
        end
    end

    p_match_reset_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && match_clr) |=> (tc == '0));

    p_stop_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (tick && match_stop && !match_clr && !hold_zero) |=> $stable(tc));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !match_clr && !match_stop && !hold_zero) |=> (tc == $past(tc) + W'(1)));

    p_no_tick_still_r2: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hold_zero) |=> $stable(tc));

endmodule

// File: rtl/match_timer.sv
module match_timer
    import mtc_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned N_CH  = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        irq
);

    localparam int unsigned AW_BITS = N_CH * ACT_W;

    ctrl_t                     ctrl;
    logic [CNT_W-1:0]          limit;
    logic [AW_BITS-1:0]        act_word;
    logic [N_CH-1:0]           flags;
    logic [N_CH-1:0][CNT_W-1:0] mval;

    logic [CNT_W-1:0] pc;
    logic [CNT_W-1:0] tc;
    logic             tick;
    logic             running;
    logic [N_CH-1:0]  hit_intr;
    logic             any_clr;
    logic             any_stop;

    logic wr_ctrl;
    logic wr_flags;

    assign running  = ctrl.run && !ctrl.halt;
    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_flags = wr_en && (addr == A_FLAGS);

    mtc_prescaler #(.W(CNT_W)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .hold_zero (ctrl.halt),
        .run       (running),
        .limit     (limit),
        .pc        (pc),
        .tick      (tick)
    );

    mtc_match_unit #(.W(CNT_W), .N(N_CH)) u_match (
        .mval     (mval),
        .act_word (act_word),
        .tc       (tc),
        .tick     (tick),
        .hit_intr (hit_intr),
        .any_clr  (any_clr),
        .any_stop (any_stop)
    );

    mtc_timer_count #(.W(CNT_W)) u_tc (
        .clk        (clk),
        .rst        (rst),
        .hold_zero  (ctrl.halt),
        .tick       (tick),
        .match_clr  (any_clr),
        .match_stop (any_stop),
        .tc         (tc)
    );

    // Control: a software write in the same clock wins over a stop event.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(wr_data[1:0]);
        end else if (any_stop) begin
            ctrl.run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            limit    <= '0;
            act_word <= '0;
        end else if (wr_en) begin
            if (addr == A_LIMIT) limit    <= wr_data[CNT_W-1:0];
            if (addr == A_ACT)   act_word <= wr_data[AW_BITS-1:0];
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_mreg
        always_ff @(posedge clk) begin
            if (rst) begin
                mval[i] <= '0;
            end else if (wr_en && (addr == A_MBASE + 4'(i))) begin
                mval[i] <= wr_data[CNT_W-1:0];
            end
        end
    end

    // Sticky flags: new events win over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~(wr_flags ? wr_data[N_CH-1:0] : '0)) | hit_intr;
        end
    end

    assign irq = |flags;

    always_comb begin
        rd_data = '0;
        unique case (addr)
            A_CTRL:  rd_data = 32'(ctrl);
            A_LIMIT: rd_data = 32'(limit);
            A_ACT:   rd_data = 32'(act_word);
            A_FLAGS: rd_data = 32'(flags);
            A_TC:    rd_data = 32'(tc);
            A_PC:    rd_data = 32'(pc);
            default: begin
                for (int i = 0; i < N_CH; i++) begin
                    if (addr == A_MBASE + 4'(i)) rd_data = 32'(mval[i]);
                end
            end
        endcase
    end

    p_stop_drops_run_r8: assert property (@(posedge clk) disable iff (rst)
        (any_stop && !wr_ctrl) |=> !ctrl.run);

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_flags |=> (($past(flags) & ~flags) == '0));

    p_irq_raise_r5: assert property (@(posedge clk) disable iff (rst)
        (|hit_intr) |=> irq);

    p_tick_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
        tick |-> running);

endmodule

// File: tb/tb_match_timer.sv
module tb_match_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    match_timer dut (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    typedef struct packed {
        logic [31:0] lim;
        logic [31:0] mv;
        logic [31:0] act;
        logic [15:0] k;
        logic [31:0] exp_tc;
        logic [31:0] exp_fl;
        logic [31:0] req;
    } vec_t;

    // req holds the requirement number for the message.
    localparam vec_t VEC [8] = '{
        '{32'd0, 32'd5, 32'h0, 16'd10, 32'd10, 32'd0, 32'd11},
        '{32'd3, 32'd0, 32'h0, 16'd10, 32'd2,  32'd0, 32'd2},
        '{32'd0, 32'd5, 32'h1, 16'd10, 32'd10, 32'd1, 32'd5},
        '{32'd0, 32'd5, 32'h2, 16'd10, 32'd4,  32'd0, 32'd7},
        '{32'd0, 32'd5, 32'h3, 16'd13, 32'd1,  32'd1, 32'd7},
        '{32'd0, 32'd5, 32'h4, 16'd10, 32'd5,  32'd0, 32'd8},
        '{32'd2, 32'd3, 32'h2, 16'd20, 32'd2,  32'd0, 32'd4},
        '{32'd1, 32'd2, 32'h5, 16'd20, 32'd2,  32'd1, 32'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic run_edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;

        // R1: reset state over every address
        do_reset();
        foreach (VEC[0].lim[i]) begin end
        for (int a = 0; a < 14; a++) begin
            rd(4'(a), v);
            check("R1 reset read", v, 32'd0);
        end
        check("R1 irq after reset", 32'(irq), 32'd0);
        wr(4'd1, 32'h1234_5678);
        rd(4'd1, v);
        check("R1 limit readback", v, 32'h1234_5678);
        wr(4'd5, 32'hCAFE_0001);
        rd(4'd5, v);
        check("R1 match1 readback", v, 32'hCAFE_0001);

        // R3: action word width
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, v);
        check("R3 action readback", v, 32'h0000_01FF);

        // Vector table: R2 R4 R5 R7 R8 R11
        for (int n = 0; n < 8; n++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[n].req, n);
            do_reset();
            wr(4'd1, VEC[n].lim);
            wr(4'd4, VEC[n].mv);
            wr(4'd2, VEC[n].act);
            wr(4'd0, 32'd1);
            run_edges(int'(VEC[n].k));
            rd(4'd12, v);
            check({tag, " tc"}, v, VEC[n].exp_tc);
            rd(4'd3, v);
            check({tag, " flags"}, v, VEC[n].exp_fl);
        end

        // R8: stop clears run bit, holds, resumes only on rewrite
        do_reset();
        wr(4'd4, 32'd5);
        wr(4'd2, 32'h4);
        wr(4'd0, 32'd1);
        run_edges(10);
        rd(4'd0, v);
        check("R8 run bit cleared", v, 32'd0);
        rd(4'd13, v);
        check("R8 prescale at zero", v, 32'd0);
        run_edges(5);
        rd(4'd12, v);
        check("R8 timer held", v, 32'd5);
        wr(4'd2, 32'h0);
        wr(4'd0, 32'd1);
        run_edges(3);
        rd(4'd12, v);
        check("R8 resumed count", v, 32'd8);

        // R5 / R6: sticky flag, write-one-to-clear
        do_reset();
        wr(4'd4, 32'd2);
        wr(4'd2, 32'h1);
        wr(4'd0, 32'd1);
        run_edges(6);
        check("R5 irq high", 32'(irq), 32'd1);
        wr(4'd3, 32'd0);
        rd(4'd3, v);
        check("R6 write zero keeps flag", v, 32'd1);
        check("R6 irq still high", 32'(irq), 32'd1);
        wr(4'd3, 32'd1);
        rd(4'd3, v);
        check("R6 write one clears", v, 32'd0);
        check("R6 irq low", 32'(irq), 32'd0);

        // R9: counter reset bit holds both counters at zero
        do_reset();
        wr(4'd0, 32'd3);
        run_edges(10);
        rd(4'd12, v);
        check("R9 timer zero", v, 32'd0);
        rd(4'd13, v);
        check("R9 prescale zero", v, 32'd0);
        wr(4'd0, 32'd1);
        run_edges(4);
        rd(4'd12, v);
        check("R9 counts after release", v, 32'd4);

        // R10: ch0 reset, ch1 stop, ch2 interrupt at the same value
        do_reset();
        wr(4'd4, 32'd4);
        wr(4'd5, 32'd4);
        wr(4'd6, 32'd4);
        wr(4'd2, 32'h62);
        wr(4'd0, 32'd1);
        run_edges(8);
        rd(4'd12, v);
        check("R10 timer halted at zero", v, 32'd0);
        rd(4'd0, v);
        check("R10 run bit cleared", v, 32'd0);
        rd(4'd3, v);
        check("R10 only ch2 flag", v, 32'd4);
        check("R10 irq", 32'(irq), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule